// File: doc/BRIEF.md
# Bus-Write Interrupt Request Receiver

This block lives inside a bus bridge and converts memory-mapped interrupt writes coming from bus adapters into prioritised interrupt requests for the host. An adapter signals an interrupt by writing its vector word to one of four request registers. These registers sit in a small window inside the bridge's node space. The register that is hit picks the host priority level, and the data word of the write is stored as the vector.

Each priority level has a small vector queue. The level's host interrupt line stays high while that queue holds anything. The host acknowledges through a read strobe. In the same cycle the block hands back the oldest vector of the highest non-empty level together with that level's priority number, and the entry leaves the queue at the next clock edge. A strap input merges all four registers onto the lowest priority level.

Top module: `irq_bridge_rx`

## Requirements
- R1: A write is taken only when `wr_addr` equals N + 0x800 + 4*k for k in 0..3. N is the node base, 0xFFFC0000 + `slot_id`*0x1000, so slot 0 puts the first register at 0xFFFC0800. Every other address has no effect on any output.
- R2: With `single_level`=0, a write to register k enters queue k. `host_irq` bit k stands for priority 0x14+k, so 0x800/0x804/0x808/0x80C map to 0x14/0x15/0x16/0x17.
- R3: With `single_level`=1, a write to any of the four registers enters queue 0 (priority 0x14).
- R4: `wr_data` of an accepted write is stored unchanged as the vector. Each level holds up to 4 vectors and returns them oldest first.
- R5: `host_irq[k]` is 1 exactly while queue k is non-empty, from the cycle after the write that fills it until the cycle after its last entry is acknowledged.
- R6: While `ack_rd`=1 and some queue is non-empty, the block sets `ack_valid`=1 in the same cycle. `ack_vector` is the oldest vector of the highest-numbered non-empty level and `ack_level` is 0x14 plus that level's index. That entry is removed at the clock edge.
- R7: While `ack_rd`=1 and all queues are empty, `ack_valid`, `ack_level` and `ack_vector` are 0 and no state changes. While `ack_rd`=0 these three outputs are also 0.
- R8: A write to a level whose queue is full is dropped and sets that level's bit in `ovf_sticky`, which stays set until reset. If an acknowledge removes an entry from that same level in the same cycle, the write is accepted instead.
- R9: A synchronous active-high `rst` empties all queues and clears `host_irq` and `ovf_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_id | input | 4 | Bridge slot number, selects the node base |
| single_level | input | 1 | Strap: 1 merges all registers onto priority 0x14 |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 32 | Bus write address |
| wr_data | input | 32 | Bus write data (the vector) |
| ack_rd | input | 1 | Host acknowledge read strobe |
| ack_valid | output | 1 | Acknowledge returned a vector |
| ack_level | output | 8 | Priority number of the returned vector |
| ack_vector | output | 32 | Returned vector |
| host_irq | output | 4 | Per-level interrupt lines, bit k is priority 0x14+k |
| ovf_sticky | output | 4 | Per-level sticky drop flags |

## Verification
A write arriving on a bus and a host acknowledge can land in the same cycle. This matters most when both target one level. If the queue is full, the acknowledge frees the slot the write needs. If the queue is empty, the acknowledge must not see the vector being written. The bench forces both cases on purpose: it fills a level to four entries and then issues a write and an acknowledge together, and it pairs a write with an acknowledge while every queue is empty. A queue-based reference model judges each cycle, and a long mixed run adds many chance collisions across different levels.

// File: rtl/irq_rx_pkg.sv
package irq_rx_pkg;
   typedef enum logic {
      MAP_SPREAD = 1'b0,
      MAP_MERGED = 1'b1
   } irq_map_e;

   function automatic int unsigned lvl_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_rx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SLOT_W = 4,
   parameter int NLEV   = 4,
   parameter logic [ADDR_W-1:0] NODE_BASE   = 32'hFFFC_0000,
   parameter logic [ADDR_W-1:0] NODE_STRIDE = 32'h0000_1000,
   parameter logic [ADDR_W-1:0] WIN_OFS     = 32'h0000_0800,
   parameter logic [ADDR_W-1:0] REG_STRIDE  = 32'h0000_0004,
   localparam int LVL_W = lvl_width(NLEV)
) (
   input  logic [SLOT_W-1:0] slot_id,
   input  irq_map_e          map_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit,
   output logic [LVL_W-1:0]  lvl
);
   logic [ADDR_W-1:0] win_base;
   logic [NLEV-1:0]   match;
   logic [LVL_W-1:0]  reg_idx;

   assign win_base = NODE_BASE + (ADDR_W'(slot_id) * NODE_STRIDE) + WIN_OFS;

   for (genvar k = 0; k < NLEV; k++) begin : g_reg
      assign match[k] = (wr_addr == win_base + ADDR_W'(k) * REG_STRIDE);
   end

   always_comb begin
      reg_idx = '0;
      for (int k = 0; k < NLEV; k++)
         if (match[k]) reg_idx = LVL_W'(k);
   end

   assign hit = wr_en && (match != '0);
   assign lvl = (map_mode == MAP_MERGED) ? '0 : reg_idx;
endmodule

// File: rtl/irq_vec_fifo.sv
module irq_vec_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              empty,
   output logic              full,
   output logic              ovf
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("irq_vec_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  cnt;
   logic              do_pop, do_push;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
         ovf    <= 1'b0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= wr_ptr + 1'b1;
         end
         if (do_pop) rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
         if (push && !do_push) ovf <= 1'b1;
      end
   end

   p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(DEPTH));

   p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
      push && full && !pop |=> full && ovf);

   p_push_grow_r4: assert property (@(posedge clk) disable iff (rst)
      push && !pop && !full |=> !empty && (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_rx_pkg::*;
#(
   parameter int NLEV = 4,
   localparam int LVL_W = lvl_width(NLEV)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NLEV-1:0]  req,
   output logic             any,
   output logic [LVL_W-1:0] sel
);
   always_comb begin
      sel = '0;
      for (int k = 0; k < NLEV; k++)
         if (req[k]) sel = LVL_W'(k);
   end
   assign any = (req != '0);

   p_pick_highest_r6: assert property (@(posedge clk) disable iff (rst)
      any |-> ((req >> sel) == NLEV'(1)));
endmodule

// File: rtl/irq_bridge_rx.sv
module irq_bridge_rx
   import irq_rx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SLOT_W   = 4,
   parameter int NLEV     = 4,
   parameter int DEPTH    = 4,
   parameter int IPL_W    = 8,
   parameter logic [IPL_W-1:0] IPL_BASE = 8'h14,
   parameter logic [ADDR_W-1:0] NODE_BASE   = 32'hFFFC_0000,
   parameter logic [ADDR_W-1:0] NODE_STRIDE = 32'h0000_1000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SLOT_W-1:0] slot_id,
   input  logic              single_level,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ack_rd,
   output logic              ack_valid,
   output logic [IPL_W-1:0]  ack_level,
   output logic [DATA_W-1:0] ack_vector,
   output logic [NLEV-1:0]   host_irq,
   output logic [NLEV-1:0]   ovf_sticky
);
   localparam int LVL_W = lvl_width(NLEV);

   if (NLEV < 2 || NLEV + int'(IPL_BASE) > (1 << IPL_W)) begin : g_bad_lvl
      $error("irq_bridge_rx: level count does not fit the priority field");
   end

   logic              wr_hit;
   logic [LVL_W-1:0]  wr_lvl;
   logic              any_pend;
   logic [LVL_W-1:0]  top_lvl;
   logic [NLEV-1:0]   empty_v, full_v, pop_v;
   logic [DATA_W-1:0] head [NLEV];
   irq_map_e          map_mode;

   assign map_mode = single_level ? MAP_MERGED : MAP_SPREAD;

   irq_addr_decode #(
      .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .NLEV(NLEV),
      .NODE_BASE(NODE_BASE), .NODE_STRIDE(NODE_STRIDE)
   ) u_dec (
      .slot_id(slot_id), .map_mode(map_mode), .wr_en(wr_en),
      .wr_addr(wr_addr), .hit(wr_hit), .lvl(wr_lvl)
   );

   for (genvar k = 0; k < NLEV; k++) begin : g_lvl
      logic push_k;
      assign push_k   = wr_hit && (wr_lvl == LVL_W'(k));
      assign pop_v[k] = ack_valid && (top_lvl == LVL_W'(k));
      irq_vec_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
         .clk(clk), .rst(rst), .push(push_k), .pop(pop_v[k]),
         .din(wr_data), .dout(head[k]), .empty(empty_v[k]),
         .full(full_v[k]), .ovf(ovf_sticky[k])
      );
   end

   assign host_irq = ~empty_v;

   irq_prio_pick #(.NLEV(NLEV)) u_pick (
      .clk(clk), .rst(rst), .req(host_irq), .any(any_pend), .sel(top_lvl)
   );

   assign ack_valid  = ack_rd && any_pend;
   assign ack_vector = ack_valid ? head[top_lvl] : '0;
   assign ack_level  = ack_valid ? (IPL_BASE + IPL_W'(top_lvl)) : '0;

   p_idle_ack_r7: assert property (@(posedge clk) disable iff (rst)
      ack_rd && !ack_valid && !wr_en |=> $stable(host_irq) && $stable(ovf_sticky));

   p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (host_irq == '0) && (ovf_sticky == '0));

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) && $past(ovf_sticky) != '0 |-> (ovf_sticky & $past(ovf_sticky)) == $past(ovf_sticky));
endmodule

// File: tb/sim_irq_bridge_rx.sv
`timescale 1ns/1ps
module sim_irq_bridge_rx;
   logic        clk = 1'b0;
   logic        rst;
   logic [3:0]  slot_id;
   logic        single_level;
   logic        wr_en;
   logic [31:0] wr_addr, wr_data;
   logic        ack_rd;
   logic        ack_valid;
   logic [7:0]  ack_level;
   logic [31:0] ack_vector;
   logic [3:0]  host_irq, ovf_sticky;

   int checks = 0;
   int fails  = 0;

   logic [31:0] mq [0:3][$];
   logic [3:0]  movf;

   always #2 clk = ~clk;

   irq_bridge_rx u0 (
      .clk(clk), .rst(rst), .slot_id(slot_id), .single_level(single_level),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ack_rd(ack_rd),
      .ack_valid(ack_valid), .ack_level(ack_level), .ack_vector(ack_vector),
      .host_irq(host_irq), .ovf_sticky(ovf_sticky)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] reg_addr(input int slot, input int k);
      return 32'hFFFC_0000 + 32'(slot) * 32'h1000 + 32'h800 + 32'(k) * 4;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0; ack_rd = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 4; k++) mq[k].delete();
      movf = '0;
   endtask

   // one clock: drive, compare against the model, then advance the model
   task automatic cyc(input logic we, input logic [31:0] a, input logic [31:0] d,
                      input logic rd, input string tag);
      logic [3:0]  e_irq;
      logic        e_val;
      logic [7:0]  e_lvl;
      logic [31:0] e_vec;
      int          top, wl;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; ack_rd = rd;
      #1;
      top = -1;
      for (int k = 0; k < 4; k++) begin
         e_irq[k] = (mq[k].size() > 0);
         if (mq[k].size() > 0) top = k;
      end
      e_val = rd && (top >= 0);
      e_lvl = e_val ? 8'(8'h14 + top) : 8'h00;
      e_vec = e_val ? mq[top][0] : 32'h0;
      chk({tag, "/R5"}, "host_irq", 32'(host_irq), 32'(e_irq));
      chk({tag, "/R8"}, "ovf_sticky", 32'(ovf_sticky), 32'(movf));
      chk({tag, e_val ? "/R6" : "/R7"}, "ack_valid", 32'(ack_valid), 32'(e_val));
      chk({tag, e_val ? "/R6" : "/R7"}, "ack_level", 32'(ack_level), 32'(e_lvl));
      chk({tag, e_val ? "/R6" : "/R7"}, "ack_vector", ack_vector, e_vec);
      wl = -1;
      if (we)
         for (int k = 0; k < 4; k++)
            if (a == reg_addr(int'(slot_id), k)) wl = single_level ? 0 : k;
      if (e_val) void'(mq[top].pop_front());
      if (wl >= 0) begin
         if (mq[wl].size() < 4) mq[wl].push_back(d);
         else movf[wl] = 1'b1;
      end
      @(posedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 32'h0, 32'h0, 1'b0, tag);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; slot_id = 4'd0; single_level = 1'b0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0; ack_rd = 1'b0;
      for (int k = 0; k < 4; k++) mq[k].delete();
      movf = '0;
      do_reset();
      // R9: state after reset; R7: empty acknowledge
      idle(2, "R9");
      cyc(1'b0, 32'h0, 32'h0, 1'b1, "R7");

      // R2: each register maps to its own level, popped highest first (R6)
      for (int k = 0; k < 4; k++) cyc(1'b1, reg_addr(0, k), 32'hA000_0000 + 32'(k), 1'b0, "R2");
      cyc(1'b1, 32'hFFFC_0800, 32'h1234_5678, 1'b0, "R2");
      for (int i = 0; i < 6; i++) cyc(1'b0, 32'h0, 32'h0, 1'b1, "R6");

      // R1: near-miss addresses and wrong slot have no effect
      cyc(1'b1, 32'hFFFC_0802, 32'hDEAD_0001, 1'b0, "R1");
      cyc(1'b1, 32'hFFFC_0810, 32'hDEAD_0002, 1'b0, "R1");
      cyc(1'b1, 32'hFFFC_07FC, 32'hDEAD_0003, 1'b0, "R1");
      cyc(1'b1, reg_addr(3, 1), 32'hDEAD_0004, 1'b0, "R1");
      cyc(1'b0, reg_addr(0, 2), 32'hDEAD_0005, 1'b0, "R1");
      cyc(1'b0, 32'h0, 32'h0, 1'b1, "R1");

      // R1: slot 5 moves the window
      slot_id = 4'd5;
      cyc(1'b1, 32'hFFFC_5808, 32'h5555_0008, 1'b0, "R1");
      cyc(1'b1, 32'hFFFC_0808, 32'h0000_0BAD, 1'b0, "R1");
      cyc(1'b0, 32'h0, 32'h0, 1'b1, "R1");
      cyc(1'b0, 32'h0, 32'h0, 1'b1, "R1");
      slot_id = 4'd0;

      // R4/R8: fill level 0 past its depth
      for (int i = 0; i < 6; i++) cyc(1'b1, reg_addr(0, 0), 32'hB000_0000 + 32'(i), 1'b0, "R8");
      idle(2, "R8");
      for (int i = 0; i < 5; i++) cyc(1'b0, 32'h0, 32'h0, 1'b1, "R4");

      // R8: full level, write and acknowledge in the same cycle
      for (int i = 0; i < 4; i++) cyc(1'b1, reg_addr(0, 1), 32'hC000_0000 + 32'(i), 1'b0, "R8");
      cyc(1'b1, reg_addr(0, 1), 32'hC000_00FF, 1'b1, "R8");
      for (int i = 0; i < 5; i++) cyc(1'b0, 32'h0, 32'h0, 1'b1, "R8");

      // R7: empty queues, write and acknowledge together
      cyc(1'b1, reg_addr(0, 3), 32'hD000_0003, 1'b1, "R7");
      cyc(1'b0, 32'h0, 32'h0, 1'b1, "R7");

      // R9: reset in the middle clears queues and drop flags
      cyc(1'b1, reg_addr(0, 2), 32'hE000_0002, 1'b0, "R9");
      do_reset();
      idle(1, "R9");

      // R3: merged mode sends every register to priority 0x14
      single_level = 1'b1;
      for (int k = 0; k < 4; k++) cyc(1'b1, reg_addr(0, k), 32'hF000_0000 + 32'(k), 1'b0, "R3");
      cyc(1'b1, reg_addr(0, 3), 32'hF000_00FF, 1'b0, "R3");
      for (int i = 0; i < 5; i++) cyc(1'b0, 32'h0, 32'h0, 1'b1, "R3");
      do_reset();
      single_level = 1'b0;

      // mixed traffic, R4 ordering and R8 collisions across levels
      for (int i = 0; i < 400; i++) begin
         int unsigned r;
         logic [31:0] a;
         r = $urandom;
         a = (r[3:0] < 4'd13) ? reg_addr(0, int'(r[5:4])) : reg_addr(0, 0) + 32'(r[7:6]) * 32'h10 + 32'h1;
         cyc(r[8] | r[9], a, $urandom, (r[12:10] < 3'd3), "R4");
      end
      idle(1, "R4");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule